// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block caches recent page translations. A lookup presents an 8-bit virtual page number and receives, in the same cycle and without any register on the path, a hit flag and the 6-bit physical page number stored for it. The default geometry is 4 sets of 4 ways, 16 entries in total. The two low bits of the page number pick the set, and the six high bits are the tag that is compared against every way of that set.

When a lookup misses, the surrounding logic walks the page table and then installs the result through the fill port. A fill carries a page number, a physical page number and a valid bit. The block chooses the way itself. A way that already holds the same tag comes first. If no way holds that tag, the lowest-numbered free way is used. If the set is full, the way under that set's rotating pointer is replaced. A single flush input empties the whole buffer in one cycle.

The fill port follows valid/ready rules. A fill is taken on a rising edge where `fill_valid` and `fill_ready` are both high. `fill_ready` is low only while `flush_all` is high. While it is low, the producer must hold its request until the flush ends. The lookup port has no back-pressure: `res_valid` simply follows `lk_valid` in the same cycle.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every way is invalid, so every lookup misses and returns a physical page number of 0.
- R2: `res_valid` equals `lk_valid` in the same cycle. `res_hit` is never high while `lk_valid` is low. `res_ppn` is 0 whenever `res_hit` is low.
- R3: The set index is `vpn[1:0]` and the tag is `vpn[7:2]`. A lookup hits, combinationally, when a valid way of the indexed set holds an equal tag, and it returns that way's physical page number. For example, page 0x0F is set 3, tag 0x03.
- R4: A page whose tag is not held by any valid way of its set misses. This covers a tag that was never written and a tag whose way was invalidated.
- R5: Within one set, at most one valid way matches any tag.
- R6: A fill whose tag is already held by a valid way of the set rewrites that way. It either installs the new physical page number, or clears the way when the fill's valid bit is 0. No other way changes.
- R7: A fill with a new tag and its valid bit set goes to the lowest-numbered invalid way. If all 4 ways are valid, it replaces the way under the set's pointer, and the pointer then advances by one modulo 4. The pointer moves only on such a replacement.
- R8: `flush_all` high at a rising edge clears every valid bit and returns every set's pointer to way 0.
- R9: `fill_ready` is low while `flush_all` is high, and a fill offered then is not installed. An accepted fill is visible to lookups from the cycle after its edge.
- R10: A fill whose valid bit is 0 and whose tag matches no valid way of its set changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_all | input | 1 | Invalidate every entry and reset the pointers |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | 8 | Virtual page number to translate |
| res_valid | output | 1 | Lookup result present (follows `lk_valid`) |
| res_hit | output | 1 | Translation found |
| res_ppn | output | 6 | Physical page number on a hit, else 0 |
| fill_valid | input | 1 | Fill request present |
| fill_ready | output | 1 | Fill can be accepted this cycle |
| fill_vpn | input | 8 | Virtual page number being installed |
| fill_ppn | input | 6 | Physical page number being installed |
| fill_pte_valid | input | 1 | Valid bit written with the entry |

## Verification
Lookup results carry no register, so the bench drives a page number during the low clock phase and samples `res_hit` and `res_ppn` 1 ns later, before the next rising edge. A fill or flush changes state at the single rising edge where it is presented. The bench therefore removes the request at the following falling edge and checks only after that, and `fill_ready` is sampled in the same low phase in which the request is raised. After each group of fills, all 256 page numbers are swept and compared against a behavioural table that the bench updates under the R6 and R7 placement rules. This exposes any misplaced, missing or surviving entry in any set.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Index of the set bit in a one-hot vector; 0 when none is set.
  function automatic int unsigned oh_to_idx(input logic [31:0] oh);
    int unsigned idx;
    idx = 0;
    for (int i = 0; i < 32; i++) begin
      if (oh[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/tlb_tag_cmp.sv
module tlb_tag_cmp #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 6
) (
  input  logic [TAG_W-1:0] tags [WAYS],
  input  logic [WAYS-1:0]  vld,
  input  logic [TAG_W-1:0] key,
  output logic [WAYS-1:0]  match
);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = vld[w] && (tags[w] == key);
  end

endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
  parameter int WAYS  = 4,
  parameter int IDX_W = 2
) (
  input  logic [WAYS-1:0]  vld,
  input  logic [WAYS-1:0]  match,
  input  logic [IDX_W-1:0] ptr,
  output logic [WAYS-1:0]  way_oh,
  output logic             rr_used
);

  logic [WAYS-1:0] free_oh;
  logic [WAYS-1:0] rr_oh;
  logic            have_free;

  always_comb begin
    free_oh   = '0;
    have_free = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!have_free && !vld[w]) begin
        free_oh[w] = 1'b1;
        have_free  = 1'b1;
      end
    end
  end

  always_comb begin
    rr_oh      = '0;
    rr_oh[ptr] = 1'b1;
  end

  // same tag first, then lowest free way, then rotating pointer
  always_comb begin
    rr_used = 1'b0;
    if (|match) begin
      way_oh = match;
    end else if (have_free) begin
      way_oh = free_oh;
    end else begin
      way_oh  = rr_oh;
      rr_used = 1'b1;
    end
  end

endmodule

// File: rtl/tlb_set_store.sv
module tlb_set_store #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  parameter int PPN_W = 6,
  parameter int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_valid,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic [PPN_W-1:0] rd_ppn
);
  import tlb_pkg::*;

  logic [TAG_W-1:0] tag_q [WAYS];
  logic [PPN_W-1:0] ppn_q [WAYS];
  logic [WAYS-1:0]  vld_q;
  logic [IDX_W-1:0] ptr_q;

  logic [WAYS-1:0]  lk_match;
  logic [WAYS-1:0]  fl_match;
  logic [WAYS-1:0]  vic_oh;
  logic             rr_used;
  logic             do_wr;
  logic [IDX_W-1:0] vic_idx;

  tlb_tag_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_cmp (
    .tags(tag_q), .vld(vld_q), .key(rd_tag), .match(lk_match)
  );

  tlb_tag_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fl_cmp (
    .tags(tag_q), .vld(vld_q), .key(wr_tag), .match(fl_match)
  );

  tlb_victim_pick #(.WAYS(WAYS), .IDX_W(IDX_W)) u_victim (
    .vld(vld_q), .match(fl_match), .ptr(ptr_q),
    .way_oh(vic_oh), .rr_used(rr_used)
  );

  // an invalid fill with no matching way is dropped
  assign do_wr   = wr_en && (wr_valid || (|fl_match));
  assign vic_idx = IDX_W'(oh_to_idx(32'(vic_oh)));

  always_comb begin
    rd_ppn = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_match[w]) rd_ppn = rd_ppn | ppn_q[w];
    end
  end
  assign rd_hit = |lk_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
      for (int w = 0; w < WAYS; w++) begin
        tag_q[w] <= '0;
        ppn_q[w] <= '0;
      end
    end else if (flush) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (do_wr) begin
      for (int w = 0; w < WAYS; w++) begin
        if (vic_oh[w]) begin
          tag_q[w] <= wr_tag;
          ppn_q[w] <= wr_ppn;
          vld_q[w] <= wr_valid;
        end
      end
      if (rr_used) begin
        ptr_q <= (ptr_q == IDX_W'(WAYS - 1)) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  // R5: no tag is held twice in a set
  p_single_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  // R7: victim choice always names exactly one way
  p_victim_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $onehot(vic_oh));

  // R7: rotation is used only on a full set with no tag match
  p_rr_only_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rr_used) |-> ((&vld_q) && !(|fl_match)));

  // R6: a valid write leaves the chosen way holding the written tag
  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && wr_valid && !flush) |=>
      (vld_q[$past(vic_idx)] && (tag_q[$past(vic_idx)] == $past(wr_tag))));

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int VPN_W = 8,
  parameter int PPN_W = 6,
  parameter int SETS  = 4,
  parameter int WAYS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_all,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             res_valid,
  output logic             res_hit,
  output logic [PPN_W-1:0] res_ppn,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_pte_valid
);

  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - SET_W;

  logic [SET_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  logic [SET_W-1:0] fl_set;
  logic [TAG_W-1:0] fl_tag;
  logic             fill_fire;
  logic [SETS-1:0]  set_hit;
  logic [PPN_W-1:0] set_ppn [SETS];

  assign lk_set = lk_vpn[SET_W-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:SET_W];
  assign fl_set = fill_vpn[SET_W-1:0];
  assign fl_tag = fill_vpn[VPN_W-1:SET_W];

  // flush takes priority: fills are held off while it is asserted
  assign fill_ready = !flush_all;
  assign fill_fire  = fill_valid && fill_ready;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic wr_here;
    assign wr_here = fill_fire && (fl_set == SET_W'(s));

    tlb_set_store #(.WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_set (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush_all),
      .wr_en   (wr_here),
      .wr_tag  (fl_tag),
      .wr_ppn  (fill_ppn),
      .wr_valid(fill_pte_valid),
      .rd_tag  (lk_tag),
      .rd_hit  (set_hit[s]),
      .rd_ppn  (set_ppn[s])
    );
  end

  assign res_valid = lk_valid;
  assign res_hit   = lk_valid && set_hit[lk_set];
  assign res_ppn   = res_hit ? set_ppn[lk_set] : '0;

  // R8: the cycle after a flush nothing hits
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !res_hit);

  // R3: an accepted valid fill is found by a lookup one cycle later
  p_fill_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_fire && fill_pte_valid) |=>
      (!lk_valid || (lk_vpn != $past(fill_vpn)) ||
       (res_hit && (res_ppn == $past(fill_ppn)))));

endmodule

// File: tb/tlb_xlate_tb_top.sv
`timescale 1ns/1ps
module tlb_xlate_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       flush_all;
  logic       lk_valid;
  logic [7:0] lk_vpn;
  logic       res_valid;
  logic       res_hit;
  logic [5:0] res_ppn;
  logic       fill_valid;
  logic       fill_ready;
  logic [7:0] fill_vpn;
  logic [5:0] fill_ppn;
  logic       fill_pte_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // behavioural table: [set][way]
  logic [5:0] m_tag [4][4];
  logic [5:0] m_ppn [4][4];
  logic       m_v   [4][4];
  int         m_ptr [4];

  always #4 clk = ~clk;

  tlb_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .res_valid(res_valid), .res_hit(res_hit), .res_ppn(res_ppn),
    .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_pte_valid(fill_pte_valid)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 4; s++) begin
      m_ptr[s] = 0;
      for (int w = 0; w < 4; w++) m_v[s][w] = 1'b0;
    end
  endtask

  // placement per R6, R7, R10
  task automatic model_fill(input logic [7:0] vpn, input logic [5:0] ppn, input logic v);
    int s;
    int sel;
    s   = int'(vpn[1:0]);
    sel = -1;
    for (int w = 0; w < 4; w++)
      if (m_v[s][w] && m_tag[s][w] == vpn[7:2]) sel = w;
    if (sel < 0 && !v) return;
    if (sel < 0)
      for (int w = 3; w >= 0; w--) if (!m_v[s][w]) sel = w;
    if (sel < 0) begin
      sel = m_ptr[s];
      m_ptr[s] = (m_ptr[s] + 1) % 4;
    end
    m_tag[s][sel] = vpn[7:2];
    m_ppn[s][sel] = ppn;
    m_v[s][sel]   = v;
  endtask

  task automatic do_fill(input logic [7:0] vpn, input logic [5:0] ppn, input logic v);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_pte_valid = v;
    #1 check("R9", "fill_ready idle", 32'(fill_ready), 32'd1);
    @(posedge clk);
    model_fill(vpn, ppn, v);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic look(input logic [7:0] vpn, input string req);
    logic       eh;
    logic [5:0] ep;
    eh = 1'b0; ep = '0;
    for (int w = 0; w < 4; w++)
      if (m_v[vpn[1:0]][w] && m_tag[vpn[1:0]][w] == vpn[7:2]) begin
        eh = 1'b1; ep = m_ppn[vpn[1:0]][w];
      end
    lk_valid = 1'b1; lk_vpn = vpn;
    #1;
    check(req, $sformatf("hit vpn 0x%02h", vpn), 32'(res_hit), 32'(eh));
    check(req, $sformatf("ppn vpn 0x%02h", vpn), 32'(res_ppn), 32'(ep));
    check("R2", "res_valid", 32'(res_valid), 32'd1);
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 256; a++) look(8'(a), req);
  endtask

  initial begin
    rst_n = 1'b0; flush_all = 1'b0; lk_valid = 1'b0; lk_vpn = '0;
    fill_valid = 1'b0; fill_vpn = '0; fill_ppn = '0; fill_pte_valid = 1'b0;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: empty after reset
    sweep("R1");

    // R3, R4: worked example in set 3, and a miss on set 0 tag 3
    do_fill(8'h0F, 6'h0D, 1'b1);
    do_fill(8'h2B, 6'h34, 1'b1);
    look(8'h0F, "R3");
    check("R3", "vpn 0x0F ppn", 32'(res_ppn), 32'h0D);
    look(8'h0C, "R4");
    check("R4", "vpn 0x0C miss", 32'(res_hit), 32'd0);

    // R2: lookup not requested
    lk_valid = 1'b0; lk_vpn = 8'h0F;
    #1;
    check("R2", "res_valid idle", 32'(res_valid), 32'd0);
    check("R2", "res_hit idle", 32'(res_hit), 32'd0);
    check("R2", "res_ppn idle", 32'(res_ppn), 32'd0);

    // R7: fill set 1 and rotate through replacements
    do_fill({6'h03, 2'd1}, 6'h2D, 1'b1);
    do_fill({6'h10, 2'd1}, 6'h01, 1'b1);
    do_fill({6'h11, 2'd1}, 6'h02, 1'b1);
    do_fill({6'h12, 2'd1}, 6'h03, 1'b1);
    sweep("R7");
    do_fill({6'h13, 2'd1}, 6'h04, 1'b1);
    do_fill({6'h14, 2'd1}, 6'h05, 1'b1);
    look({6'h03, 2'd1}, "R7");
    check("R7", "first victim evicted", 32'(res_hit), 32'd0);
    sweep("R7");

    // R6: rewrite existing tag, then invalidate one
    do_fill({6'h11, 2'd1}, 6'h2A, 1'b1);
    sweep("R6");
    do_fill({6'h12, 2'd1}, 6'h00, 1'b0);
    sweep("R6");
    // R7: freed way taken before rotation; pointer did not move
    do_fill({6'h15, 2'd1}, 6'h06, 1'b1);
    do_fill({6'h16, 2'd1}, 6'h07, 1'b1);
    sweep("R7");

    // R10: invalid fill on an absent tag of a full set
    do_fill({6'h0F, 2'd1}, 6'h3F, 1'b0);
    sweep("R10");

    // R5, R7: load every set past capacity
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 6; k++)
        do_fill({6'((s * 7 + k * 13) & 63), 2'(s)}, 6'((s * 16 + k * 5) & 63), 1'b1);
    sweep("R5");

    // R8, R9: flush with a fill offered in the same cycle
    @(negedge clk);
    flush_all = 1'b1; fill_valid = 1'b1;
    fill_vpn = 8'h55; fill_ppn = 6'h22; fill_pte_valid = 1'b1;
    #1 check("R9", "fill_ready during flush", 32'(fill_ready), 32'd0);
    @(posedge clk);
    model_clear();
    @(negedge clk);
    flush_all = 1'b0; fill_valid = 1'b0;
    look(8'h55, "R9");
    sweep("R8");

    // R8: pointer back at way 0 after flush
    for (int k = 0; k < 5; k++)
      do_fill({6'(k + 8), 2'd2}, 6'(k + 40), 1'b1);
    look({6'd8, 2'd2}, "R8");
    check("R8", "pointer restarted at way 0", 32'(res_hit), 32'd0);
    sweep("R8");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule